// File: doc/BRIEF.md
# Store-to-Load Memory Ordering Guard

This block sits beside a small in-order reorder buffer and keeps memory accesses from loads and stores in a safe order. Each issued memory operation takes the next slot at the tail of a circular buffer and is marked as a load or a store. Later, address updates and store-data updates arrive for individual slots. The block decides, for every load slot, whether the load may start its memory access now. It also drives a single memory write port, and that port only ever carries the store at the head of the buffer.

A load is held back while any store older than it in program order has an address that is not yet known, or has a known address equal to the load's address. Age is taken from the circular distance to the head, so the ordering stays correct after the indices wrap. Stores reach memory one per cycle and only from the head, so memory writes follow program order. A blocked load's grant simply stays low until the store in its way commits or resolves to a different address. A flush discards every uncommitted slot in one cycle.

Top module: `mem_order_guard`

## Requirements
- R1: After reset the buffer is empty: `full` is 0, `alloc_idx` is 0, `ld_grant` is all zeros and `wr_en` is 0, even while `commit_req` is high.
- R2: An accepted issue request takes the slot shown on `alloc_idx`, and `alloc_idx` then advances by one modulo 8. After 8 live slots `full` is 1. An issue request while full is ignored: `alloc_idx` and `full` keep their values.
- R3: A live load slot whose address is known, and which has no older store, has its bit in `ld_grant` (bit i is slot i) set. A load whose address is unknown is never granted.
- R4: A load is not granted while an older live store has an unknown address.
- R5: A load is not granted while an older live store has a known address equal to the load's address. An older store with a different known address does not block it.
- R6: Stores issued after a load (younger stores) never affect that load's grant.
- R7: `wr_en` rises only while `commit_req` is high and the head slot is a store with known address and data. In that cycle `wr_addr` and `wr_data` carry that store's address and data, and the head then advances by one. A head store without data produces no write.
- R8: Once the blocking store commits, the load it blocked is granted.
- R9: With `commit_req` high, a head load with a known address retires without a memory write, and its grant bit drops.
- R10: A flush empties the buffer in one cycle and moves the tail to the head, so the next `alloc_idx` equals the head index. During a flush cycle `wr_en` is 0 even with `commit_req` high.
- R11: Age is measured from the head circularly. After a wrap, a store at a numerically larger index that was issued earlier blocks a load at a smaller index, and a store issued later does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue request for a new memory operation |
| alloc_store | input | 1 | 1 = store, 0 = load, for the issue request |
| alloc_idx | output | 3 | Slot the next issue request takes (tail) |
| full | output | 1 | All slots are live |
| addr_valid | input | 1 | Address update strobe |
| addr_idx | input | 3 | Slot receiving the address |
| addr_val | input | 32 | Computed address |
| data_valid | input | 1 | Store data update strobe |
| data_idx | input | 3 | Slot receiving the data |
| data_val | input | 32 | Store data |
| commit_req | input | 1 | Retire the head slot if it is ready |
| flush | input | 1 | Discard all uncommitted slots |
| ld_grant | output | 8 | Bit i set: the load in slot i may access memory |
| wr_en | output | 1 | Memory write from the head store |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 32 | Memory write data |

## Verification
The grant logic is driven with loads against stores whose addresses are still unknown, known and equal, and known and different. This separates a missing check for unresolved addresses from a missing or inverted comparison. Younger stores are placed behind granted loads to catch age checks that ignore program order. A buffer filled after the head has moved puts older stores at larger indices than younger loads, which exposes a comparison done on raw indices instead of on distance from the head. Commit is tried with a head store that lacks data, a head load, a ready store, and a flush in the same cycle, to tell a correct write gate from one that leaks writes.

// File: rtl/mog_pkg.sv
package mog_pkg;
   // per-slot status bits kept for each buffer entry
   typedef struct packed {
      logic live;
      logic is_st;
      logic a_ok;
      logic d_ok;
   } mog_slot_t;
endpackage

// File: rtl/mog_ptrs.sv
module mog_ptrs #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   output logic [IW-1:0] head,
   output logic [IW-1:0] tail,
   output logic          full
);
   localparam logic [IW:0] FULLV = (IW+1)'(DEPTH);

   logic [IW:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (flush) begin
         tail  <= head;
         count <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         count <= count + {{IW{1'b0}}, push} - {{IW{1'b0}}, pop};
      end
   end

   assign full = (count == FULLV);

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULLV);

   a_r10_flush_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tail == $past(head)) && (count == '0));
endmodule

// File: rtl/mog_slots.sv
module mog_slots
   import mog_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic                      push_st,
   input  logic [IW-1:0]             tail,
   input  logic                      pop,
   input  logic [IW-1:0]             head,
   input  logic                      flush,
   input  logic                      a_we,
   input  logic [IW-1:0]             a_idx,
   input  logic [AW-1:0]             a_val,
   input  logic                      d_we,
   input  logic [IW-1:0]             d_idx,
   input  logic [DW-1:0]             d_val,
   output mog_slot_t [DEPTH-1:0]     slot,
   output logic [DEPTH-1:0][AW-1:0]  s_addr,
   output logic [DEPTH-1:0][DW-1:0]  s_data
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [IW-1:0] ME = IW'(i);

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            slot[i] <= '0;
         end else if (push && tail == ME) begin
            slot[i] <= '{live: 1'b1, is_st: push_st, a_ok: 1'b0, d_ok: 1'b0};
         end else begin
            if (pop && head == ME) slot[i].live <= 1'b0;
            if (a_we && a_idx == ME && slot[i].live) slot[i].a_ok <= 1'b1;
            if (d_we && d_idx == ME && slot[i].live && slot[i].is_st)
               slot[i].d_ok <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (a_we && a_idx == ME) s_addr[i] <= a_val;
         if (d_we && d_idx == ME) s_data[i] <= d_val;
      end
   end
endmodule

// File: rtl/mog_grant.sv
module mog_grant
   import mog_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [IW-1:0]             head,
   input  mog_slot_t [DEPTH-1:0]     slot,
   input  logic [DEPTH-1:0][AW-1:0]  s_addr,
   output logic [DEPTH-1:0]          grant
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_ld
      logic [IW-1:0] age_me;
      logic          hold;

      assign age_me = IW'(i) - head;

      always_comb begin
         hold = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (slot[j].live && slot[j].is_st &&
                ((IW'(j) - head) < age_me) &&
                (!slot[j].a_ok || s_addr[j] == s_addr[i]))
               hold = 1'b1;
         end
      end

      assign grant[i] = slot[i].live && !slot[i].is_st && slot[i].a_ok && !hold;
   end
endmodule

// File: rtl/mem_order_guard.sv
module mem_order_guard
   import mog_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic             alloc_store,
   output logic [IW-1:0]    alloc_idx,
   output logic             full,
   input  logic             addr_valid,
   input  logic [IW-1:0]    addr_idx,
   input  logic [AW-1:0]    addr_val,
   input  logic             data_valid,
   input  logic [IW-1:0]    data_idx,
   input  logic [DW-1:0]    data_val,
   input  logic             commit_req,
   input  logic             flush,
   output logic [DEPTH-1:0] ld_grant,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mem_order_guard: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("mem_order_guard: AW and DW must be positive");
   end

   logic [IW-1:0]            head, tail;
   logic                     push, pop, head_ready;
   mog_slot_t [DEPTH-1:0]    slot;
   logic [DEPTH-1:0][AW-1:0] s_addr;
   logic [DEPTH-1:0][DW-1:0] s_data;
   mog_slot_t                hs;

   assign hs         = slot[head];
   assign head_ready = hs.live && hs.a_ok && (!hs.is_st || hs.d_ok);
   assign push       = alloc_valid && !full && !flush;
   assign pop        = commit_req && head_ready && !flush;

   mog_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
      .head(head), .tail(tail), .full(full)
   );

   mog_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_st(alloc_store), .tail(tail),
      .pop(pop), .head(head), .flush(flush),
      .a_we(addr_valid), .a_idx(addr_idx), .a_val(addr_val),
      .d_we(data_valid), .d_idx(data_idx), .d_val(data_val),
      .slot(slot), .s_addr(s_addr), .s_data(s_data)
   );

   mog_grant #(.DEPTH(DEPTH), .AW(AW)) u_grant (
      .head(head), .slot(slot), .s_addr(s_addr), .grant(ld_grant)
   );

   assign alloc_idx = tail;
   assign wr_en     = pop && hs.is_st;
   assign wr_addr   = s_addr[head];
   assign wr_data   = s_data[head];

   // R7: a write leaves only from a ready head store, and the head moves on
   a_r7_write_from_head: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (hs.is_st && hs.d_ok && hs.a_ok));
   a_r7_head_advance: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (head == $past(head) + 1'b1));
   // R3: a head load with a known address has nothing older to wait for
   a_r3_head_load_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (hs.live && !hs.is_st && hs.a_ok) |-> ld_grant[head]);
   // R2: an issue request while full changes nothing
   a_r2_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && full && !pop && !flush) |=> (full && alloc_idx == $past(alloc_idx)));
   // R10: no write in a flush cycle
   a_r10_flush_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !wr_en);
endmodule

// File: tb/mem_order_guard_test.sv
module mem_order_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_valid = 0, alloc_store = 0;
   logic [2:0]  alloc_idx;
   logic        full;
   logic        addr_valid = 0;
   logic [2:0]  addr_idx = 0;
   logic [31:0] addr_val = 0;
   logic        data_valid = 0;
   logic [2:0]  data_idx = 0;
   logic [31:0] data_val = 0;
   logic        commit_req = 0, flush = 0;
   logic [7:0]  ld_grant;
   logic        wr_en;
   logic [31:0] wr_addr, wr_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mem_order_guard uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_store(alloc_store),
      .alloc_idx(alloc_idx), .full(full),
      .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_val(addr_val),
      .data_valid(data_valid), .data_idx(data_idx), .data_val(data_val),
      .commit_req(commit_req), .flush(flush),
      .ld_grant(ld_grant), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic issue(input bit st, input int exp_idx, input string req);
      @(negedge clk);
      chk(req, alloc_idx, exp_idx);
      alloc_valid = 1; alloc_store = st;
      tick();
      alloc_valid = 0;
   endtask

   task automatic put_addr(input int idx, input logic [31:0] a);
      @(negedge clk);
      addr_valid = 1; addr_idx = idx[2:0]; addr_val = a;
      tick();
      addr_valid = 0;
   endtask

   task automatic put_data(input int idx, input logic [31:0] d);
      @(negedge clk);
      data_valid = 1; data_idx = idx[2:0]; data_val = d;
      tick();
      data_valid = 0;
   endtask

   task automatic commit(input bit exp_wr, input logic [31:0] ea, input logic [31:0] ed,
                         input string req);
      @(negedge clk);
      commit_req = 1;
      #1;
      chk(req, wr_en, exp_wr);
      if (exp_wr) begin
         chk(req, wr_addr, ea);
         chk(req, wr_data, ed);
      end
      tick();
      commit_req = 0;
   endtask

   task automatic do_flush(input bit with_commit, input string req);
      @(negedge clk);
      flush = 1; commit_req = with_commit;
      #1;
      chk(req, wr_en, 1'b0);
      tick();
      flush = 0; commit_req = 0;
   endtask

   task automatic t_reset();
      chk("R1 full", full, 0);
      chk("R1 alloc_idx", alloc_idx, 0);
      chk("R1 ld_grant", ld_grant, 0);
      commit(0, 0, 0, "R1 commit on empty");
   endtask

   task automatic t_lone_load();
      issue(0, 0, "R2 first index");
      chk("R3 no grant before address", ld_grant, 8'h00);
      put_addr(0, 32'h100);
      chk("R3 lone load granted", ld_grant, 8'h01);
      commit(0, 0, 0, "R9 load retires without write");
      chk("R9 grant dropped", ld_grant, 8'h00);
   endtask

   task automatic t_unknown_and_diff();
      issue(1, 1, "R2 index advances");
      issue(0, 2, "R2 index advances");
      put_addr(2, 32'h200);
      chk("R4 unknown older store blocks", ld_grant, 8'h00);
      put_addr(1, 32'h300);
      chk("R5 different address passes", ld_grant, 8'h04);
      do_flush(0, "R10 flush");
      chk("R10 tail to head", alloc_idx, 1);
      chk("R10 grants cleared", ld_grant, 8'h00);
   endtask

   task automatic t_match_commit();
      issue(1, 1, "R10 reuse head slot");
      issue(0, 2, "R2 index");
      put_addr(2, 32'h40);
      put_addr(1, 32'h40);
      chk("R5 equal address blocks", ld_grant, 8'h00);
      commit(0, 0, 0, "R7 store without data not written");
      put_data(1, 32'hDEAD_BEEF);
      chk("R5 still blocked with data", ld_grant, 8'h00);
      commit(1, 32'h40, 32'hDEAD_BEEF, "R7 head store written");
      chk("R8 load released", ld_grant, 8'h04);
      commit(0, 0, 0, "R9 head load retires");
   endtask

   task automatic t_younger_store();
      issue(0, 3, "R2 index");
      put_addr(3, 32'h80);
      chk("R3 granted", ld_grant, 8'h08);
      issue(1, 4, "R2 index");
      chk("R6 younger unknown store ignored", ld_grant, 8'h08);
      put_addr(4, 32'h80);
      chk("R6 younger matching store ignored", ld_grant, 8'h08);
      commit(0, 0, 0, "R9 load retires");
      chk("R9 grant dropped", ld_grant, 8'h00);
      commit(0, 0, 0, "R7 store needs data");
      put_data(4, 32'h1234);
      do_flush(1, "R10 flush beats commit");
      chk("R10 tail to head", alloc_idx, 4);
      chk("R10 not full", full, 0);
   endtask

   task automatic t_wrap();
      // order from head 4: L4 L5 S6 L7 L0 S1 L2 L3
      issue(0, 4, "R2 wrap"); issue(0, 5, "R2 wrap"); issue(1, 6, "R2 wrap");
      issue(0, 7, "R2 wrap"); issue(0, 0, "R2 wrap"); issue(1, 1, "R2 wrap");
      issue(0, 2, "R2 wrap");
      chk("R2 not yet full", full, 0);
      issue(0, 3, "R2 wrap");
      chk("R2 full", full, 1);
      @(negedge clk);
      alloc_valid = 1; alloc_store = 1;
      tick();
      alloc_valid = 0;
      chk("R2 full ignores issue", full, 1);
      chk("R2 index held", alloc_idx, 4);
      put_addr(5, 32'h10);
      put_addr(0, 32'h10);
      put_addr(2, 32'h10);
      chk("R11 older store at larger index blocks", ld_grant, 8'h20);
      put_addr(6, 32'h10);
      chk("R11 match after wrap blocks", ld_grant, 8'h20);
      put_addr(6, 32'h20);
      chk("R11 younger store at smaller index ignored", ld_grant, 8'h21);
      put_addr(1, 32'h10);
      chk("R5 match blocks only younger load", ld_grant, 8'h21);
      do_flush(0, "R10 flush full buffer");
      chk("R10 not full", full, 0);
      chk("R10 tail to head", alloc_idx, 4);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_lone_load();
      t_unknown_and_diff();
      t_match_commit();
      t_younger_store();
      t_wrap();
      done = 1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end
endmodule